// File: doc/BRIEF.md
# Sixteen-Bit Compare PWM Channel

This block produces one PWM output level from a 16-bit timebase that lives outside it. Software writes a 16-bit compare value as bytes over an 8-bit register port. Every cycle, a comparator checks the whole timebase value against the whole compare value. On a match, an output flag sets. When the timebase reports a wrap, the flag clears. The output therefore goes high part way through each timebase period and returns low when the next period starts.

The two halves of the compare value are written one byte at a time. A write to the low byte turns the comparator off. A write to the high byte turns it back on. Matches are therefore never taken against a half-updated value. A separate mode bit switches the channel on or off. While the channel is off, the output stays low.

Top module: `pwm16_cmp_channel`

## Requirements
- R1: After reset the output is low, the compare value is 0x0000, comparison is enabled and the channel mode is off. The output first rises once the mode is enabled and the timebase reads 0 without a wrap strobe.
- R2: With the channel on and comparison enabled, the output is high in the cycle after the timebase equals the full 16-bit compare value. If only one byte matches, the output does not change.
- R3: With the channel on, a wrap strobe clears the output in the following cycle.
- R4: When a match and a wrap strobe occur in the same cycle, the output is low in the following cycle.
- R5: A write to address 0 loads the compare low byte and disables comparison. Matches have no effect until the high byte is written.
- R6: A write to address 1 loads the compare high byte and enables comparison.
- R7: Address 2 bit 0 is the channel mode bit. While the mode is off, the output is low in every cycle after the write takes effect, and matches do not set it.
- R8: The timebase counts 0 to 65535, with the wrap strobe asserted in the cycle where it reads 0. For a nonzero compare value C, the output is high for 65536 − C cycles of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tb_count | input | 16 | Shared timebase value |
| tb_wrap | input | 1 | Timebase wrap strobe, one cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 compare low, 1 compare high, 2 mode |
| reg_wdata | input | 8 | Register write data |
| pwm_out | output | 1 | PWM output level |

## Verification
The compare function is exercised with the following input patterns, each separating one behaviour from the others:
- **Exact full match.** Shows that the comparator sets the output.
- **High byte equal, low byte different.** Shows that the comparison spans all 16 bits and not a single byte.
- **Timebase equal to the new low byte and the old high byte, between the two byte writes.** Shows that comparison is gated during an update.
- **Match coinciding with the wrap strobe.** Shows the clear priority.
- **Match while the channel is off.** Shows the mode gating.
- **One full 65536-count period at a compare value of 0xF000.** Measures the number of high cycles, which separates a correct duty cycle from off-by-one set or clear timing.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NUM_BYTES = 2;
  localparam int unsigned CMP_W     = DATA_W * NUM_BYTES;
  localparam int unsigned ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CMP_LO = 2'd0,
    ADDR_CMP_HI = 2'd1,
    ADDR_MODE   = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/pwm16_rst_sync.sv
module pwm16_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pwm16_regs.sv
module pwm16_regs #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BYTES = 2,
  parameter int unsigned ADDR_W    = 2,
  localparam int unsigned CMP_W    = DATA_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CMP_W-1:0]  cmp_val,
  output logic              cmp_en,
  output logic              mode_en
);
  localparam int unsigned LAST_BYTE = NUM_BYTES - 1;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_BYTES);

  logic [NUM_BYTES-1:0] lane_hit;

  // One register lane per compare byte; byte i lives at address i.
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    logic [DATA_W-1:0] byte_q;
    logic [DATA_W-1:0] byte_d;

    assign lane_hit[i] = wr_en && (addr == ADDR_W'(i));

    always_comb begin
      byte_d = byte_q;
      if (lane_hit[i]) byte_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign cmp_val[i*DATA_W +: DATA_W] = byte_q;
  end

  // Compare-enable: low byte write disarms, high byte write re-arms.
  logic en_q, en_d;
  always_comb begin
    en_d = en_q;
    if (lane_hit[0])         en_d = 1'b0;
    if (lane_hit[LAST_BYTE]) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_d;
  end

  // Channel mode bit.
  logic mode_q, mode_d, mode_hit;
  assign mode_hit = wr_en && (addr == MODE_ADDR);

  always_comb begin
    mode_d = mode_q;
    if (mode_hit) mode_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  assign cmp_en  = en_q;
  assign mode_en = mode_q;

  p_lo_write_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=> !cmp_en);
  p_hi_write_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(LAST_BYTE)) |=> cmp_en);
  p_hi_write_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(LAST_BYTE)) |=>
      cmp_val[LAST_BYTE*DATA_W +: DATA_W] == $past(wdata));
endmodule

// File: rtl/pwm16_cmp.sv
module pwm16_cmp #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BYTES = 2,
  localparam int unsigned CMP_W    = DATA_W * NUM_BYTES
) (
  input  logic [CMP_W-1:0] count,
  input  logic [CMP_W-1:0] cmp_val,
  input  logic             cmp_en,
  output logic             match
);
  logic [NUM_BYTES-1:0] byte_eq;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_eq
    assign byte_eq[i] = (count[i*DATA_W +: DATA_W] == cmp_val[i*DATA_W +: DATA_W]);
  end

  assign match = cmp_en && (&byte_eq);
endmodule

// File: rtl/pwm16_out_latch.sv
module pwm16_out_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_r, q_d;

  always_comb begin
    if (!mode_en)   q_d = 1'b0;
    else if (clr_i) q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
    else            q_d = q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;

  p_wrap_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && clr_i) |=> !q);
  p_match_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && set_i && !clr_i) |=> q);
  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> !q);
  p_mode_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !q);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && !set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/pwm16_cmp_channel.sv
module pwm16_cmp_channel
  import pwm16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMP_W-1:0]  tb_count,
  input  logic              tb_wrap,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              pwm_out
);
  logic             rst_n_s;
  logic [CMP_W-1:0] cmp_val;
  logic             cmp_en;
  logic             mode_en;
  logic             match;

  pwm16_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  pwm16_regs #(.DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .cmp_val (cmp_val),
    .cmp_en  (cmp_en),
    .mode_en (mode_en)
  );

  pwm16_cmp #(.DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_cmp (
    .count   (tb_count),
    .cmp_val (cmp_val),
    .cmp_en  (cmp_en),
    .match   (match)
  );

  pwm16_out_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .mode_en (mode_en),
    .set_i   (match),
    .clr_i   (tb_wrap),
    .q       (pwm_out)
  );

  p_match_is_exact_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    match |-> (tb_count == cmp_val));
  p_disarmed_no_match_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cmp_en |-> !match);
endmodule

// File: tb/pwm16_cmp_channel_tb.sv
module pwm16_cmp_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tb_count = '0;
  logic        tb_wrap = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        pwm_out;

  always #4 clk = ~clk;

  pwm16_cmp_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_wrap(tb_wrap),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pwm_out(pwm_out)
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  int checks = 0;
  int failures = 0;
  int duty_high = 0;

  // Reference state built from the requirements.
  logic [7:0] m_lo = 8'h00, m_hi = 8'h00;
  logic m_en = 1'b1, m_mode = 1'b0, m_out = 1'b0;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: pwm_out=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected output.
  task automatic step(input logic [15:0] cnt, input logic wrap, input logic wr,
                      input logic [1:0] a, input logic [7:0] d, input string tag);
    logic nxt;
    item_t it;
    @(negedge clk);
    tb_count = cnt; tb_wrap = wrap; reg_wr = wr; reg_addr = a; reg_wdata = d;
    if (!m_mode)                              nxt = 1'b0;
    else if (wrap)                            nxt = 1'b0;
    else if (m_en && cnt == {m_hi, m_lo})     nxt = 1'b1;
    else                                      nxt = m_out;
    m_out = nxt;
    if (wr) begin
      case (a)
        2'd0: begin m_lo = d; m_en = 1'b0; end
        2'd1: begin m_hi = d; m_en = 1'b1; end
        2'd2: m_mode = d[0];
        default: ;
      endcase
    end
    it.exp = nxt; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: samples after each edge and compares against the queue head.
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.tag == "R8" && pwm_out === 1'b1) duty_high++;
      check(it.tag, pwm_out, it.exp);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1", pwm_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", pwm_out, 1'b0);

    // R7: mode off at reset, count 0 matches reset compare but no effect.
    step(16'h0000, 0, 0, 0, 0, "R7");
    step(16'h0005, 0, 1, 2'd2, 8'h01, "R7");
    // R1: reset compare 0 with enable set -> match at count 0.
    step(16'h0000, 0, 0, 0, 0, "R1");
    step(16'h0007, 0, 0, 0, 0, "R1");
    // R3: wrap clears.
    step(16'h0008, 1, 0, 0, 0, "R3");
    // R5/R6: two-byte update with a would-be match in between.
    step(16'h0009, 0, 1, 2'd0, 8'h34, "R5");
    step(16'h0034, 0, 0, 0, 0, "R5");
    step(16'h0034, 0, 1, 2'd1, 8'h12, "R6");
    step(16'h0034, 0, 0, 0, 0, "R2");
    step(16'h1200, 0, 0, 0, 0, "R2");
    step(16'h3434, 0, 0, 0, 0, "R2");
    step(16'h1234, 0, 0, 0, 0, "R2");
    step(16'h1235, 0, 0, 0, 0, "R2");
    // R4: match and wrap together.
    step(16'h1234, 1, 0, 0, 0, "R4");
    step(16'h1235, 0, 0, 0, 0, "R4");
    // R7: channel switched off while high, then match ignored.
    step(16'h1234, 0, 0, 0, 0, "R2");
    step(16'h1236, 0, 1, 2'd2, 8'h00, "R7");
    step(16'h1234, 0, 0, 0, 0, "R7");
    step(16'h1234, 0, 0, 0, 0, "R7");
    // R8: one full period at compare 0xF000.
    step(16'h0001, 0, 1, 2'd2, 8'h01, "R7");
    step(16'h0002, 0, 1, 2'd0, 8'h00, "R5");
    step(16'h0003, 0, 1, 2'd1, 8'hF0, "R6");
    for (int c = 0; c < 65536; c++) step(16'(c), (c == 0), 0, 0, 0, "R8");
    step(16'h0000, 1, 0, 0, 0, "R3");
    repeat (3) @(negedge clk);
    checks++;
    if (duty_high != 4096) begin
      failures++;
      $display("FAIL R8: high cycles=%0d expected=%0d", duty_high, 4096);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule